// File: doc/BRIEF.md
# Serial Dot-Matrix Glyph Generator

This block keeps the dot patterns of 64 glyphs, each an 8x8 grid stored as eight 8-bit rows, and sends the rows of a chosen glyph out one dot at a time. A 6-bit glyph code picks the glyph. An internal row counter picks which of its rows feeds the row shifter. The counter moves to the next row on a rising edge of the row-advance strobe, and the clear strobe sends it back to row 0. A falling edge of the load strobe copies the selected row into the shifter. Each cycle with the dot enable high shifts one dot out, the leftmost dot first.

All strobes are sampled against the system clock, and edges are found from the value in the previous cycle. The pattern store is a registered-read ROM that can map onto block RAM. Its contents are computed when the design is built, so the selected row reaches the shifter input one clock after the code or the row counter changes.

Top module: `dotchar_gen`

## Requirements
- R1: While `rst` is high at a clock edge, `line_o` becomes 0 and `dot_o` becomes 0.
- R2: The stored row for code c and row r is the byte ((c*8 + r)*29 + 11) mod 256. Bit 7 is the leftmost dot, and a 1 means a lit dot.
- R3: A rising edge on `line_i` (high now, low at the previous clock) with `clr_i` low adds 1 to `line_o` at that clock edge, and the count wraps from 7 to 0.
- R4: `line_o` does not change at a clock with neither a rising edge on `line_i` nor `clr_i` high. Holding `line_i` high does not advance it again.
- R5: `clr_i` high at a clock edge sets `line_o` to 0, even when a `line_i` rising edge occurs in the same cycle.
- R6: A falling edge on `le_i` (low now, high at the previous clock) loads into the shifter the row that `code_i` and `line_o` selected at the previous clock.
- R7: Each clock with `dot_en_i` high shifts the row one place toward the MSB and fills with 0. `dot_o` shows the MSB, and after eight shifts it stays 0.
- R8: When a load and `dot_en_i` occur in the same cycle, the load wins.
- R9: With no load and `dot_en_i` low, `dot_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| code_i | input | 6 | Glyph select code |
| dot_en_i | input | 1 | Shift one dot per clock while high |
| line_i | input | 1 | Row-advance strobe, acts on its rising edge |
| le_i | input | 1 | Row load strobe, acts on its falling edge |
| clr_i | input | 1 | Row counter clear, level sampled |
| dot_o | output | 1 | Serial dot, 1 = lit |
| line_o | output | 3 | Current row index |

## Verification
The edge checks compare each strobe with its value one clock earlier. They therefore assume `line_i` and `le_i` are low while reset is asserted, so that no edge appears in the first cycle after reset. The stimulus keeps both strobes low throughout reset. It drives every input only on the falling clock edge, so each strobe level is seen for whole clock cycles. Directed full-glyph scans are followed by a random mix of strobes and codes, all within those rules.

// File: rtl/dotchar_pkg.sv
package dotchar_pkg;
  localparam int CODE_W_DEF = 6;
  localparam int ROWS_DEF   = 8;
  localparam int COLS_DEF   = 8;

  // Row pattern for flat index idx = code*ROWS + row
  function automatic int row_pattern(input int idx);
    return (idx * 29) + 11;
  endfunction
endpackage

// File: rtl/glyph_rom.sv
module glyph_rom #(
  parameter int ADDR_W = 9,
  parameter int COLS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  output logic [COLS-1:0]   data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [COLS-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = COLS'(dotchar_pkg::row_pattern(i));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) data <= '0;
    else     data <= mem[addr];
  end
endmodule

// File: rtl/line_ctr.sv
module line_ctr #(
  parameter int ROWS = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    line_i,
  input  logic                    clr_i,
  output logic [$clog2(ROWS)-1:0] line_o
);
  localparam int LW = $clog2(ROWS);

  logic line_d;
  logic step;

  assign step = line_i & ~line_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_d <= 1'b0;
      line_o <= '0;
    end else begin
      line_d <= line_i;
      if (clr_i)     line_o <= '0;
      else if (step) line_o <= (line_o == LW'(ROWS - 1)) ? '0 : line_o + 1'b1;
    end
  end
endmodule

// File: rtl/row_shifter.sv
module row_shifter #(
  parameter int COLS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [COLS-1:0] row_i,
  input  logic            le_i,
  input  logic            dot_en_i,
  output logic            dot_o
);
  logic            le_d;
  logic            load;
  logic [COLS-1:0] sh;

  assign load  = le_d & ~le_i;
  assign dot_o = sh[COLS-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      le_d <= 1'b0;
      sh   <= '0;
    end else begin
      le_d <= le_i;
      if (load)          sh <= row_i;
      else if (dot_en_i) sh <= {sh[COLS-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/dotchar_gen.sv
module dotchar_gen #(
  parameter int CODE_W = dotchar_pkg::CODE_W_DEF,
  parameter int ROWS   = dotchar_pkg::ROWS_DEF,
  parameter int COLS   = dotchar_pkg::COLS_DEF
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [CODE_W-1:0]       code_i,
  input  logic                    dot_en_i,
  input  logic                    line_i,
  input  logic                    le_i,
  input  logic                    clr_i,
  output logic                    dot_o,
  output logic [$clog2(ROWS)-1:0] line_o
);
  localparam int LW     = $clog2(ROWS);
  localparam int ADDR_W = CODE_W + LW;

  logic [COLS-1:0] row_sel;

  line_ctr #(.ROWS(ROWS)) u_line (
    .clk(clk), .rst(rst), .line_i(line_i), .clr_i(clr_i), .line_o(line_o)
  );

  glyph_rom #(.ADDR_W(ADDR_W), .COLS(COLS)) u_rom (
    .clk(clk), .rst(rst), .addr({code_i, line_o}), .data(row_sel)
  );

  row_shifter #(.COLS(COLS)) u_shift (
    .clk(clk), .rst(rst), .row_i(row_sel), .le_i(le_i),
    .dot_en_i(dot_en_i), .dot_o(dot_o)
  );
endmodule

// File: rtl/dotchar_chk.sv
module dotchar_chk #(
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          dot_en_i,
  input logic          line_i,
  input logic          le_i,
  input logic          clr_i,
  input logic          dot_o,
  input logic [LW-1:0] line_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (line_o == '0 && dot_o == 1'b0));

  // R3
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (line_i && !$past(line_i) && !clr_i) |=> (line_o == LW'($past(line_o) + 1'b1)));

  // R4
  line_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr_i && !(line_i && !$past(line_i))) |=> $stable(line_o));

  // R5
  line_clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (line_o == '0));

  // R9
  dot_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!dot_en_i && !(!le_i && $past(le_i))) |=> $stable(dot_o));
endmodule

bind dotchar_gen dotchar_chk #(.LW($clog2(ROWS))) u_chk (
  .clk(clk), .rst(rst), .dot_en_i(dot_en_i), .line_i(line_i), .le_i(le_i),
  .clr_i(clr_i), .dot_o(dot_o), .line_o(line_o)
);

// File: tb/test_dotchar_gen.sv
module test_dotchar_gen;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] code_i = '0;
  logic       dot_en_i = 1'b0, line_i = 1'b0, le_i = 1'b0, clr_i = 1'b0;
  logic       dot_o;
  logic [2:0] line_o;

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dotchar_gen i_dotchar_gen (
    .clk(clk), .rst(rst), .code_i(code_i), .dot_en_i(dot_en_i), .line_i(line_i),
    .le_i(le_i), .clr_i(clr_i), .dot_o(dot_o), .line_o(line_o)
  );

  // Reference model state
  int m_line = 0, m_row = 0, m_sh = 0;
  bit m_lp = 0, m_ep = 0;

  function automatic int glyph(int c, int r);
    return ((c * 8 + r) * 29 + 11) % 256; // R2
  endfunction

  always @(posedge clk) begin
    int n_line, n_row, n_sh;
    if (rst) begin
      n_line = 0; n_row = 0; n_sh = 0;
    end else begin
      n_line = clr_i ? 0 : (line_i && !m_lp) ? (m_line + 1) % 8 : m_line;
      n_row  = glyph(int'(code_i), m_line);
      n_sh   = (!le_i && m_ep) ? m_row : dot_en_i ? (m_sh << 1) & 255 : m_sh;
    end
    m_lp = rst ? 1'b0 : line_i;
    m_ep = rst ? 1'b0 : le_i;
    m_line = n_line; m_row = n_row; m_sh = n_sh;
    #(CLK_PERIOD/4);
    checks++;
    if (int'(line_o) != m_line) begin
      errors++;
      $display("FAIL %s line_o actual=%0d expected=%0d", tag, line_o, m_line);
    end
    checks++;
    if (dot_o != m_sh[7]) begin
      errors++;
      $display("FAIL %s dot_o actual=%0b expected=%0b", tag, dot_o, m_sh[7]);
    end
  end

  task automatic drive(input int c, input bit den, input bit ln, input bit le, input bit cl);
    @(negedge clk);
    code_i = 6'(c); dot_en_i = den; line_i = ln; le_i = le; clr_i = cl;
  endtask

  // Full scan of one glyph: clear, then per row load, 8 dots, advance
  task automatic scan(input int c);
    drive(c, 0, 0, 0, 1);
    drive(c, 0, 0, 0, 0);
    for (int r = 0; r < 8; r++) begin
      drive(c, 0, 0, 1, 0);
      drive(c, 0, 0, 0, 0);
      for (int d = 0; d < 8; d++) drive(c, 1, 0, 0, 0);
      drive(c, 0, 1, 0, 0);
      drive(c, 0, 0, 0, 0);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin
    tag = "R1";
    repeat (3) drive(0, 0, 0, 0, 0);
    rst = 1'b0;
    tag = "R2 R6 R7";
    scan(0); scan(63); scan(21); scan(42);
    tag = "R7";
    drive(5, 0, 0, 1, 0); drive(5, 0, 0, 0, 0);
    repeat (12) drive(5, 1, 0, 0, 0);
    tag = "R3";
    for (int i = 0; i < 10; i++) begin drive(1, 0, 1, 0, 0); drive(1, 0, 0, 0, 0); end
    tag = "R4";
    repeat (5) drive(1, 0, 1, 0, 0);
    drive(1, 0, 0, 0, 0);
    tag = "R5";
    drive(1, 0, 1, 0, 1); drive(1, 0, 0, 0, 0);
    drive(1, 0, 1, 0, 0); drive(1, 0, 1, 0, 1); drive(1, 0, 0, 0, 0);
    tag = "R8";
    drive(9, 1, 0, 1, 0); drive(9, 1, 0, 0, 0); drive(9, 1, 0, 0, 0);
    tag = "R9";
    drive(9, 0, 0, 1, 0); drive(9, 0, 0, 0, 0);
    repeat (4) drive(9, 0, 0, 0, 0);
    tag = "mixed R3 R5 R6 R8";
    for (int i = 0; i < 3000; i++)
      drive(int'($urandom_range(0, 63)), 1'($urandom), 1'($urandom),
            1'($urandom), ($urandom_range(0, 15) == 0));
    tag = "R1";
    @(negedge clk); rst = 1'b1;
    drive(0, 0, 0, 0, 0);
    drive(0, 0, 0, 0, 0);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule